// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block is the host-facing line and modem control slice of one 16550-style UART channel. It keeps the modem control register and the divisor-access bit of the line control register. It drives the active-low data-terminal-ready and request-to-send pins, and it decides whether the channel's interrupt request reaches the serial interrupt encoder. It also assembles the low part of the line status register and raises the line-status interrupt request. The baud generator, shift registers, FIFOs and interrupt frame encoder sit next to it and see it only through plain signals.

Two small state machines carry the behaviour. The mode machine has the states MODE_NORMAL and MODE_LOOPBACK. An MCR write with bit 4 set takes the ENTER_LOOP transition, and an MCR write with bit 4 clear takes the LEAVE_LOOP transition. Any other cycle holds the state. In MODE_LOOPBACK the modem status seen by the channel comes from the control bits instead of the pins, and both output pins rest high. The overrun machine has the states OVR_CLEAR and OVR_SEEN. An overrun pulse takes the MARK transition. A status read with no overrun pulse in the same cycle takes the ACK transition. Any other cycle holds the state.

Register offsets are 3 (line control, only bit 7 kept), 4 (modem control) and 5 (line status). The neighbouring decoders rely on these offsets. A read returns data on the clock after the request.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After synchronous reset, sel_divisor is 0, the stored MCR value is 0, dtr_pin_n and rts_pin_n are 1, loop_active is 0, the overrun flag is clear and bus_rdata is 0.
- R2: A write to offset 3 stores bus_wdata[7] as sel_divisor. A read of offset 3 returns sel_divisor in bit 7 and 0 in bits 6:0.
- R3: In normal mode, dtr_pin_n equals the inverse of MCR bit 0 and rts_pin_n equals the inverse of MCR bit 1.
- R4: A write to offset 4 stores bits 4:0. Bits 7:5 are ignored and read back as 0. A read of offset 4 returns the stored value.
- R5: In normal mode, serirq_req equals chan_irq_req AND MCR bit 3.
- R6: MCR bit 4 selects loopback, reported on loop_active. In loopback, dtr_pin_n and rts_pin_n are 1, and serirq_req equals chan_irq_req with no gating.
- R7: In normal mode, ms_cts, ms_dsr, ms_ri and ms_dcd are the inverses of the matching pins. In loopback they equal MCR bits 1, 0, 2 and 3 in that order.
- R8: Bit 0 of a line status read (offset 5) equals rx_ready in the cycle of the request.
- R9: An rx_overrun pulse sets a sticky flag, read as line status bit 1. A status read clears it unless an overrun pulse arrives in the same cycle. The read returns the value the flag had before the clock edge.
- R10: Line status bits 2, 3 and 4 carry head_parity_err, head_frame_err and head_break while rx_ready is 1, and are 0 otherwise. Bits 7:5 read 0. ls_irq is ls_irq_en AND (overrun flag OR any of bits 4:2).
- R11: bus_rdata is registered. It shows the addressed value one cycle after bus_rd, and 0 after a cycle without bus_rd or after a read of any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sel_divisor | output | 1 | Divisor-access select for the neighbouring decoder |
| cts_pin_n | input | 1 | Clear-to-send pin, active low |
| dsr_pin_n | input | 1 | Data-set-ready pin, active low |
| ri_pin_n | input | 1 | Ring indicator pin, active low |
| dcd_pin_n | input | 1 | Carrier detect pin, active low |
| dtr_pin_n | output | 1 | Data-terminal-ready pin, active low |
| rts_pin_n | output | 1 | Request-to-send pin, active low |
| ms_cts | output | 1 | Effective clear-to-send, active high |
| ms_dsr | output | 1 | Effective data-set-ready, active high |
| ms_ri | output | 1 | Effective ring indicator, active high |
| ms_dcd | output | 1 | Effective carrier detect, active high |
| loop_active | output | 1 | Loopback mode in force |
| chan_irq_req | input | 1 | Channel interrupt request, already filtered by the enables |
| serirq_req | output | 1 | Request passed to the serial interrupt encoder |
| rx_ready | input | 1 | A character waits in the receive holding register or FIFO |
| rx_overrun | input | 1 | Overrun event pulse |
| head_parity_err | input | 1 | Parity error of the head character |
| head_frame_err | input | 1 | Framing error of the head character |
| head_break | input | 1 | Break flag of the head character |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| ls_irq | output | 1 | Line-status interrupt request |

## Verification
The pin, modem status, serirq_req and ls_irq outputs follow their inputs with no delay. They follow register contents from the edge that performs the write or the overrun update. bus_rdata appears one edge after the read strobe and holds the value from before that edge. The bench applies inputs just after a falling edge and updates its model at the next rising edge from the values present there. It checks every output at the falling edge after that, so each result is compared in the first cycle it is due. Directed cases cover overrun and status read in the same cycle, error bits with no character present, and reserved MCR bits. A seeded random run covers mode changes and read and write collisions.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_LOOPBACK = 1'b1
    } mode_e;

    typedef enum logic {
        OVR_CLEAR = 1'b0,
        OVR_SEEN  = 1'b1
    } ovr_e;

    localparam int REG_W    = 8;
    localparam int MCR_USED = 5;
    localparam logic [REG_W-1:0] MCR_MASK = REG_W'((1 << MCR_USED) - 1);
endpackage

// File: rtl/uart_mc_regs.sv
module uart_mc_regs
    import uart_mc_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int LCR_ADDR = 3,
    parameter int MCR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              dlab_o,
    output logic [REG_W-1:0]  mcr_o,
    output mode_e             mode_o
);
    localparam logic [ADDR_W-1:0] LCR_A = ADDR_W'(LCR_ADDR);
    localparam logic [ADDR_W-1:0] MCR_A = ADDR_W'(MCR_ADDR);

    mode_e            mode_q, mode_d;
    logic             dlab_q;
    logic [REG_W-1:0] mcr_q;
    logic             mcr_hit, lcr_hit;

    assign mcr_hit = bus_wr && (bus_addr == MCR_A);
    assign lcr_hit = bus_wr && (bus_addr == LCR_A);

    // Mode next-state: ENTER_LOOP / LEAVE_LOOP on an MCR write
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL:   if (mcr_hit && bus_wdata[4])  mode_d = MODE_LOOPBACK;
            MODE_LOOPBACK: if (mcr_hit && !bus_wdata[4]) mode_d = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_NORMAL;
        else     mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlab_q <= 1'b0;
            mcr_q  <= '0;
        end else begin
            if (lcr_hit) dlab_q <= bus_wdata[REG_W-1];
            if (mcr_hit) mcr_q  <= bus_wdata & MCR_MASK;
        end
    end

    always_comb begin
        mode_o = mode_q;
        dlab_o = dlab_q;
        mcr_o  = mcr_q;
    end

    a_r2_dlab_write: assert property (@(posedge clk) disable iff (rst)
        lcr_hit |=> (dlab_o == $past(bus_wdata[REG_W-1])));
    a_r4_mcr_write: assert property (@(posedge clk) disable iff (rst)
        mcr_hit |=> (mcr_o == ($past(bus_wdata) & MCR_MASK)));
    a_r6_mode_matches_bit: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_LOOPBACK) == mcr_o[4]);
endmodule

// File: rtl/uart_mc_route.sv
module uart_mc_route
    import uart_mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mode_e      mode,
    input  logic [3:0] mcr_low,
    input  logic       cts_pin_n,
    input  logic       dsr_pin_n,
    input  logic       ri_pin_n,
    input  logic       dcd_pin_n,
    input  logic       chan_irq_req,
    output logic       dtr_pin_n,
    output logic       rts_pin_n,
    output logic       ms_cts,
    output logic       ms_dsr,
    output logic       ms_ri,
    output logic       ms_dcd,
    output logic       serirq_req,
    output logic       loop_active
);
    always_comb begin
        unique case (mode)
            MODE_NORMAL: begin
                dtr_pin_n   = ~mcr_low[0];
                rts_pin_n   = ~mcr_low[1];
                ms_cts      = ~cts_pin_n;
                ms_dsr      = ~dsr_pin_n;
                ms_ri       = ~ri_pin_n;
                ms_dcd      = ~dcd_pin_n;
                serirq_req  = chan_irq_req & mcr_low[3];
                loop_active = 1'b0;
            end
            MODE_LOOPBACK: begin
                dtr_pin_n   = 1'b1;
                rts_pin_n   = 1'b1;
                ms_cts      = mcr_low[1];
                ms_dsr      = mcr_low[0];
                ms_ri       = mcr_low[2];
                ms_dcd      = mcr_low[3];
                serirq_req  = chan_irq_req;
                loop_active = 1'b1;
            end
        endcase
    end

    a_r6_pins_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOPBACK) |-> (dtr_pin_n && rts_pin_n));
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_NORMAL) && !mcr_low[3]) |-> !serirq_req);
    a_r7_loop_status: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOPBACK) |-> ({ms_dcd, ms_ri, ms_dsr, ms_cts} ==
                                     {mcr_low[3], mcr_low[2], mcr_low[0], mcr_low[1]}));
endmodule

// File: rtl/uart_mc_lsr.sv
module uart_mc_lsr
    import uart_mc_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int LSR_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              rx_ready,
    input  logic              rx_overrun,
    input  logic              head_parity_err,
    input  logic              head_frame_err,
    input  logic              head_break,
    input  logic              ls_irq_en,
    output logic [REG_W-1:0]  lsr_value,
    output logic              ls_irq
);
    localparam logic [ADDR_W-1:0] LSR_A = ADDR_W'(LSR_ADDR);

    ovr_e       ovr_q, ovr_d;
    logic       lsr_read;
    logic [2:0] err_bits;

    assign lsr_read = bus_rd && (bus_addr == LSR_A);

    // MARK on an overrun pulse, ACK on a status read (MARK wins)
    always_comb begin
        ovr_d = ovr_q;
        unique case (ovr_q)
            OVR_CLEAR: if (rx_overrun) ovr_d = OVR_SEEN;
            OVR_SEEN:  if (lsr_read && !rx_overrun) ovr_d = OVR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ovr_q <= OVR_CLEAR;
        else     ovr_q <= ovr_d;
    end

    always_comb begin
        err_bits  = rx_ready ? {head_break, head_frame_err, head_parity_err} : 3'b000;
        lsr_value = {3'b000, err_bits, (ovr_q == OVR_SEEN), rx_ready};
        ls_irq    = ls_irq_en && ((ovr_q == OVR_SEEN) || (err_bits != 3'b000));
    end

    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> lsr_value[1]);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (lsr_read && !rx_overrun) |=> !lsr_value[1]);
    a_r10_irq_enable: assert property (@(posedge clk) disable iff (rst)
        !ls_irq_en |-> !ls_irq);
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import uart_mc_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int LCR_ADDR = 3,
    parameter int MCR_ADDR = 4,
    parameter int LSR_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              sel_divisor,
    input  logic              cts_pin_n,
    input  logic              dsr_pin_n,
    input  logic              ri_pin_n,
    input  logic              dcd_pin_n,
    output logic              dtr_pin_n,
    output logic              rts_pin_n,
    output logic              ms_cts,
    output logic              ms_dsr,
    output logic              ms_ri,
    output logic              ms_dcd,
    output logic              loop_active,
    input  logic              chan_irq_req,
    output logic              serirq_req,
    input  logic              rx_ready,
    input  logic              rx_overrun,
    input  logic              head_parity_err,
    input  logic              head_frame_err,
    input  logic              head_break,
    input  logic              ls_irq_en,
    output logic              ls_irq
);
    localparam logic [ADDR_W-1:0] LCR_A = ADDR_W'(LCR_ADDR);
    localparam logic [ADDR_W-1:0] MCR_A = ADDR_W'(MCR_ADDR);
    localparam logic [ADDR_W-1:0] LSR_A = ADDR_W'(LSR_ADDR);

    mode_e            mode;
    logic             dlab;
    logic [REG_W-1:0] mcr;
    logic [REG_W-1:0] lsr_value;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    uart_mc_regs #(.ADDR_W(ADDR_W), .LCR_ADDR(LCR_ADDR), .MCR_ADDR(MCR_ADDR)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .dlab_o(dlab), .mcr_o(mcr), .mode_o(mode)
    );

    uart_mc_route u_route (
        .clk(clk), .rst(rst), .mode(mode), .mcr_low(mcr[3:0]),
        .cts_pin_n(cts_pin_n), .dsr_pin_n(dsr_pin_n), .ri_pin_n(ri_pin_n),
        .dcd_pin_n(dcd_pin_n), .chan_irq_req(chan_irq_req),
        .dtr_pin_n(dtr_pin_n), .rts_pin_n(rts_pin_n),
        .ms_cts(ms_cts), .ms_dsr(ms_dsr), .ms_ri(ms_ri), .ms_dcd(ms_dcd),
        .serirq_req(serirq_req), .loop_active(loop_active)
    );

    uart_mc_lsr #(.ADDR_W(ADDR_W), .LSR_ADDR(LSR_ADDR)) u_lsr (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .head_parity_err(head_parity_err), .head_frame_err(head_frame_err),
        .head_break(head_break), .ls_irq_en(ls_irq_en),
        .lsr_value(lsr_value), .ls_irq(ls_irq)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == LCR_A)      rd_mux = {dlab, 7'b0};
        else if (bus_addr == MCR_A) rd_mux = mcr;
        else if (bus_addr == LSR_A) rd_mux = lsr_value;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata   = rdata_q;
    assign sel_divisor = dlab;

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 8'h00));
    a_r4_reserved_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == MCR_A) |=> (bus_rdata[7:5] == 3'b000));
endmodule

// File: tb/tb_uart_modem_ctrl.sv
module tb_uart_modem_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sel_divisor;
    logic       cts_pin_n = 1'b1, dsr_pin_n = 1'b1, ri_pin_n = 1'b1, dcd_pin_n = 1'b1;
    logic       dtr_pin_n, rts_pin_n, ms_cts, ms_dsr, ms_ri, ms_dcd, loop_active;
    logic       chan_irq_req = 1'b0, serirq_req;
    logic       rx_ready = 1'b0, rx_overrun = 1'b0;
    logic       head_parity_err = 1'b0, head_frame_err = 1'b0, head_break = 1'b0;
    logic       ls_irq_en = 1'b0, ls_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic       m_dlab;
    logic [4:0] m_mcr;
    logic       m_ovr;
    logic [7:0] m_rd;

    always #4 clk = ~clk;

    uart_modem_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sel_divisor(sel_divisor), .cts_pin_n(cts_pin_n), .dsr_pin_n(dsr_pin_n),
        .ri_pin_n(ri_pin_n), .dcd_pin_n(dcd_pin_n), .dtr_pin_n(dtr_pin_n),
        .rts_pin_n(rts_pin_n), .ms_cts(ms_cts), .ms_dsr(ms_dsr), .ms_ri(ms_ri),
        .ms_dcd(ms_dcd), .loop_active(loop_active), .chan_irq_req(chan_irq_req),
        .serirq_req(serirq_req), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .head_parity_err(head_parity_err), .head_frame_err(head_frame_err),
        .head_break(head_break), .ls_irq_en(ls_irq_en), .ls_irq(ls_irq)
    );

    function automatic logic [2:0] exp_errs();
        return rx_ready ? {head_break, head_frame_err, head_parity_err} : 3'b000;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd3:    return {m_dlab, 7'b0};
            3'd4:    return {3'b000, m_mcr};
            3'd5:    return {3'b000, exp_errs(), m_ovr, rx_ready};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic lp;
        lp = m_mcr[4];
        chk("R2 sel_divisor", {7'b0, sel_divisor}, {7'b0, m_dlab});
        chk("R6 loop_active", {7'b0, loop_active}, {7'b0, lp});
        chk("R3/R6 dtr_pin_n", {7'b0, dtr_pin_n}, {7'b0, lp ? 1'b1 : ~m_mcr[0]});
        chk("R3/R6 rts_pin_n", {7'b0, rts_pin_n}, {7'b0, lp ? 1'b1 : ~m_mcr[1]});
        chk("R7 modem status", {4'b0, ms_cts, ms_dsr, ms_ri, ms_dcd},
            lp ? {4'b0, m_mcr[1], m_mcr[0], m_mcr[2], m_mcr[3]}
               : {4'b0, ~cts_pin_n, ~dsr_pin_n, ~ri_pin_n, ~dcd_pin_n});
        chk("R5/R6 serirq_req", {7'b0, serirq_req},
            {7'b0, lp ? chan_irq_req : (chan_irq_req & m_mcr[3])});
        chk("R10 ls_irq", {7'b0, ls_irq},
            {7'b0, ls_irq_en & (m_ovr | (exp_errs() != 3'b000))});
        chk("R11/R8/R9 bus_rdata", bus_rdata, m_rd);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_dlab = 1'b0; m_mcr = '0; m_ovr = 1'b0; m_rd = '0;
        end else begin
            m_rd = bus_rd ? exp_read(bus_addr) : 8'h00;
            if (bus_wr && bus_addr == 3'd3) m_dlab = bus_wdata[7];
            if (bus_wr && bus_addr == 3'd4) m_mcr = bus_wdata[4:0];
            if (rx_overrun) m_ovr = 1'b1;
            else if (bus_rd && bus_addr == 3'd5) m_ovr = 1'b0;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_bus();
        bus_wr = 1'b0; bus_rd = 1'b0; rx_overrun = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset values
        chk("R1 dtr_pin_n", {7'b0, dtr_pin_n}, 8'h01);
        chk("R1 rts_pin_n", {7'b0, rts_pin_n}, 8'h01);
        chk("R1 sel_divisor", {7'b0, sel_divisor}, 8'h00);
        chk("R1 loop_active", {7'b0, loop_active}, 8'h00);
        chk("R1 bus_rdata", bus_rdata, 8'h00);
        bus_rd = 1'b1; bus_addr = 3'd4; step();
        chk("R1 MCR reads 0", bus_rdata, 8'h00);
        idle_bus();

        // R4: reserved bits ignored
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'hE3; step();
        bus_wr = 1'b0; bus_rd = 1'b1; step();
        chk("R4 MCR readback", bus_rdata, 8'h03);
        chk("R3 dtr low", {7'b0, dtr_pin_n}, 8'h00);
        idle_bus();

        // R2: divisor select
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'hFF; step();
        bus_wr = 1'b0; bus_rd = 1'b1; step();
        chk("R2 LCR readback", bus_rdata, 8'h80);
        chk("R2 sel_divisor set", {7'b0, sel_divisor}, 8'h01);
        idle_bus();

        // R9: overrun and status read in the same cycle
        rx_overrun = 1'b1; step();
        rx_overrun = 1'b1; bus_rd = 1'b1; bus_addr = 3'd5; rx_ready = 1'b0; step();
        chk("R9 read shows old flag", bus_rdata, 8'h02);
        rx_overrun = 1'b0; step();
        chk("R9 flag kept by same-cycle pulse", bus_rdata, 8'h02);
        step();
        chk("R9 flag cleared by read", bus_rdata, 8'h00);

        // R10: error bits hidden without a character, R8 ready bit
        head_parity_err = 1'b1; head_frame_err = 1'b1; head_break = 1'b1;
        ls_irq_en = 1'b1; step();
        chk("R10 errors masked", bus_rdata, 8'h00);
        chk("R10 no irq", {7'b0, ls_irq}, 8'h00);
        rx_ready = 1'b1; step();
        chk("R8/R10 status with char", bus_rdata, 8'h1D);
        idle_bus();

        // R6/R7: loopback
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h1B; chan_irq_req = 1'b1; step();
        idle_bus(); step();
        chk("R6 dtr idle in loop", {7'b0, dtr_pin_n}, 8'h01);
        chk("R7 cts from rts bit", {7'b0, ms_cts}, 8'h01);
        chk("R6 irq ungated", {7'b0, serirq_req}, 8'h01);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            bus_addr = (r < 8) ? 3'(3 + (r % 3)) : 3'($urandom_range(0, 7));
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_rd = ($urandom_range(0, 1) == 1);
            bus_wdata = 8'($urandom());
            {cts_pin_n, dsr_pin_n, ri_pin_n, dcd_pin_n} = 4'($urandom());
            chan_irq_req = 1'($urandom());
            rx_ready = 1'($urandom());
            rx_overrun = ($urandom_range(0, 15) == 0);
            {head_parity_err, head_frame_err, head_break} = 3'($urandom());
            ls_irq_en = 1'($urandom());
            step();
        end
        idle_bus();
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule